// File: doc/BRIEF.md
# Torus Dimension-Order Route Computation

This unit computes the next hop for a head flit at one router of a k-ary two-dimensional torus. Each dimension is a ring: two nodes are neighbours when one coordinate differs by one modulo k and the other is equal. The unit takes the router's own coordinates and the destination coordinates from the head flit. It returns the output port, which is X+, X-, Y+, Y- or local eject, and a virtual channel class.

The route is deterministic. The flit travels along X until the X coordinate matches, and only then along Y. On each ring the shorter way round is taken, and a tie goes the positive way. The virtual channel class is 1 whenever the remaining path crosses a wraparound link in either dimension, and 0 otherwise. This breaks the cyclic channel dependency that each ring would otherwise form.

The result is registered. It appears one cycle after a valid head flit and is held until the next head flit. Body and tail flits reuse the decision already taken for the packet.

Top module: `torus_dor_route`

## Requirements
- R1: While `rst_ni` is low, `route_valid_o` is 0, `out_port_o` is 0 (eject) and `vc_o` is 0.
- R2: A cycle with `flit_valid_i`=1 and `flit_head_i`=1 makes `route_valid_o`=1 in the next cycle. In that cycle `out_port_o` and `vc_o` carry the route for the coordinates that were sampled. In every other cycle `route_valid_o` is 0.
- R3: A cycle without a head flit (`flit_valid_i`=0, or `flit_head_i`=0) leaves `out_port_o` and `vc_o` unchanged in the next cycle, whatever the coordinate inputs are.
- R4: The port encoding is 0=eject, 1=X+, 2=X-, 3=Y+, 4=Y-. When the destination X differs from the local X, the port is 1 or 2.
- R5: When the X coordinates are equal and the Y coordinates differ, the port is 3 or 4.
- R6: On each ring the forward distance is f = (dst-cur) mod k. The unit takes the positive direction when 0 < f <= floor(k/2), and the negative direction otherwise. A tie at f = k/2 therefore goes positive.
- R7: When both destination coordinates equal the local coordinates, the port is 0 and `vc_o` is 0.
- R8: `vc_o` is 1 exactly when the remaining route crosses a wraparound link in either dimension. The route crosses in X when the direction is positive and dst_x < cur_x, or the direction is negative and dst_x > cur_x. The same rule applies to Y.
- R9: Applying the unit hop by hop from any source reaches the destination in at most 2*floor(k/2) hops, and no hop in X follows a hop in Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | A flit is present this cycle |
| flit_head_i | input | 1 | The present flit is a head flit |
| cur_x_i | input | CW | Local X coordinate |
| cur_y_i | input | CW | Local Y coordinate |
| dst_x_i | input | CW | Destination X from the head flit |
| dst_y_i | input | CW | Destination Y from the head flit |
| route_valid_o | output | 1 | A new route is presented this cycle |
| out_port_o | output | 3 | Selected output port (0 eject, 1 X+, 2 X-, 3 Y+, 4 Y-) |
| vc_o | output | 1 | Virtual channel class (1 if the remaining path wraps) |

## Verification
A hand-worked table covers the cases that separate the rules. It includes short moves in each direction, the tie at k/2 going positive, wrapped and unwrapped moves in both dimensions, an X move whose later Y leg wraps (class 1), and self-addressed flits. An exhaustive sweep of all 256 source and destination pairs for k=4 is compared against an independent model. Hop-by-hop walks then confirm that every route arrives, stays within the length bound and never turns from Y back to X. Directed tests apply body flits with changed coordinates to show that the outputs hold, and apply a reset in the middle of the run.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
  typedef enum logic [2:0] {
    PORT_EJECT = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XM    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YM    = 3'd4
  } port_e;

  typedef struct packed {
    logic move;
    logic plus;
    logic wrap;
  } ring_step_t;
endpackage

// File: rtl/torus_ring_step.sv
module torus_ring_step
  import torus_rt_pkg::*;
#(
  parameter int K  = 4,
  parameter int CW = 2
) (
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] dst_i,
  output ring_step_t    step_o
);
  localparam int DW   = CW + 1;
  localparam int HALF = K / 2;

  logic [DW-1:0] cur_w, dst_w, fwd;

  assign cur_w = {1'b0, cur_i};
  assign dst_w = {1'b0, dst_i};

  // forward distance modulo K
  always_comb begin
    if (dst_w >= cur_w) fwd = dst_w - cur_w;
    else                fwd = dst_w + DW'(K) - cur_w;
  end

  always_comb begin
    step_o.move = (fwd != '0);
    step_o.plus = step_o.move && (fwd <= DW'(HALF));
    // positive pass wraps k-1 -> 0, negative pass wraps 0 -> k-1
    step_o.wrap = step_o.move &&
                  (step_o.plus ? (dst_w < cur_w) : (dst_w > cur_w));
  end
endmodule

// File: rtl/torus_dor_sel.sv
module torus_dor_sel
  import torus_rt_pkg::*;
#(
  parameter int K  = 4,
  parameter int CW = 2
) (
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output port_e         port_o,
  output logic          vc_o
);
  localparam int NDIM = 2;

  logic [CW-1:0] cur_d [NDIM];
  logic [CW-1:0] dst_d [NDIM];
  ring_step_t    step_d [NDIM];

  assign cur_d[0] = cur_x_i;
  assign cur_d[1] = cur_y_i;
  assign dst_d[0] = dst_x_i;
  assign dst_d[1] = dst_y_i;

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    torus_ring_step #(.K(K), .CW(CW)) u_ring (
      .cur_i  (cur_d[d]),
      .dst_i  (dst_d[d]),
      .step_o (step_d[d])
    );
  end

  // X strictly before Y
  always_comb begin
    if (step_d[0].move)      port_o = step_d[0].plus ? PORT_XP : PORT_XM;
    else if (step_d[1].move) port_o = step_d[1].plus ? PORT_YP : PORT_YM;
    else                     port_o = PORT_EJECT;
  end

  // any wrap on the remaining path selects class 1
  assign vc_o = step_d[0].wrap | step_d[1].wrap;
endmodule

// File: rtl/torus_dor_route.sv
module torus_dor_route
  import torus_rt_pkg::*;
#(
  parameter int K  = 4,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flit_valid_i,
  input  logic          flit_head_i,
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  output logic          route_valid_o,
  output logic [2:0]    out_port_o,
  output logic          vc_o
);
  port_e nxt_port;
  logic  nxt_vc;
  logic  head_fire;

  assign head_fire = flit_valid_i & flit_head_i;

  torus_dor_sel #(.K(K), .CW(CW)) u_sel (
    .cur_x_i (cur_x_i),
    .cur_y_i (cur_y_i),
    .dst_x_i (dst_x_i),
    .dst_y_i (dst_y_i),
    .port_o  (nxt_port),
    .vc_o    (nxt_vc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_valid_o <= 1'b0;
      out_port_o    <= PORT_EJECT;
      vc_o          <= 1'b0;
    end else begin
      route_valid_o <= head_fire;
      if (head_fire) begin
        out_port_o <= nxt_port;
        vc_o       <= nxt_vc;
      end
    end
  end

  assert_valid_after_head_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_fire |=> route_valid_o);

  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_fire |=> !route_valid_o);

  assert_hold_on_body_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_fire |=> ($stable(out_port_o) && $stable(vc_o)));

  assert_x_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_fire && dst_x_i != cur_x_i) |=>
      (out_port_o == PORT_XP || out_port_o == PORT_XM));

  assert_y_after_x_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_fire && dst_x_i == cur_x_i && dst_y_i != cur_y_i) |=>
      (out_port_o == PORT_YP || out_port_o == PORT_YM));

  assert_eject_class0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_valid_o && out_port_o == PORT_EJECT) |-> !vc_o);
endmodule

// File: tb/torus_dor_route_test.sv
module torus_dor_route_test;
  localparam int K  = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          flit_valid_i = 1'b0;
  logic          flit_head_i = 1'b0;
  logic [CW-1:0] cur_x_i = '0, cur_y_i = '0, dst_x_i = '0, dst_y_i = '0;
  logic          route_valid_o;
  logic [2:0]    out_port_o;
  logic          vc_o;

  int checks = 0;
  int failures = 0;

  always #10ns clk = ~clk;

  torus_dor_route #(.K(K), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .flit_valid_i(flit_valid_i), .flit_head_i(flit_head_i),
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .route_valid_o(route_valid_o), .out_port_o(out_port_o), .vc_o(vc_o)
  );

  // {cx, cy, dx, dy, port, vc}
  typedef struct packed {
    logic [1:0] cx, cy, dx, dy;
    logic [2:0] port;
    logic       vc;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 2'd0, 2'd0, 3'd0, 1'b0},
    '{2'd0, 2'd0, 2'd1, 2'd0, 3'd1, 1'b0},
    '{2'd0, 2'd0, 2'd3, 2'd0, 3'd2, 1'b1},
    '{2'd0, 2'd0, 2'd2, 2'd0, 3'd1, 1'b0},
    '{2'd2, 2'd0, 2'd0, 2'd0, 3'd1, 1'b1},
    '{2'd3, 2'd1, 2'd0, 2'd1, 3'd1, 1'b1},
    '{2'd1, 2'd1, 2'd1, 2'd2, 3'd3, 1'b0},
    '{2'd1, 2'd0, 2'd1, 2'd3, 3'd4, 1'b1},
    '{2'd1, 2'd2, 2'd1, 2'd1, 3'd4, 1'b0},
    '{2'd1, 2'd1, 2'd2, 2'd0, 3'd1, 1'b0},
    '{2'd1, 2'd0, 2'd2, 2'd3, 3'd1, 1'b1},
    '{2'd2, 2'd3, 2'd2, 2'd3, 3'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent model of one ring: returns {move, plus, wrap}
  function automatic logic [2:0] ring_model(input int c, input int d);
    int f;
    logic mv, pl, wr;
    f  = ((d - c) % K + K) % K;
    mv = (f != 0);
    pl = mv && (f <= K / 2);
    wr = 1'b0;
    if (mv) begin
      if (pl) wr = (c + f) >= K;
      else    wr = (c - (K - f)) < 0;
    end
    return {mv, pl, wr};
  endfunction

  function automatic logic [3:0] route_model(input int cx, input int cy, input int dx, input int dy);
    logic [2:0] rx, ry;
    logic [2:0] p;
    rx = ring_model(cx, dx);
    ry = ring_model(cy, dy);
    if (rx[2])      p = rx[1] ? 3'd1 : 3'd2;
    else if (ry[2]) p = ry[1] ? 3'd3 : 3'd4;
    else            p = 3'd0;
    return {p, rx[0] | ry[0]};
  endfunction

  task automatic send_head(input int cx, input int cy, input int dx, input int dy);
    @(negedge clk);
    cur_x_i = CW'(cx); cur_y_i = CW'(cy); dst_x_i = CW'(dx); dst_y_i = CW'(dy);
    flit_valid_i = 1'b1; flit_head_i = 1'b1;
    @(negedge clk);
    flit_valid_i = 1'b0; flit_head_i = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] exp_r;
    logic [2:0] hold_port;
    logic       hold_vc;

    // R1 reset state
    #35ns;
    chk(route_valid_o == 1'b0, "R1 valid", int'(route_valid_o), 0);
    chk(out_port_o == 3'd0, "R1 port", int'(out_port_o), 0);
    chk(vc_o == 1'b0, "R1 vc", int'(vc_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // vector table: R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      send_head(VECS[i].cx, VECS[i].cy, VECS[i].dx, VECS[i].dy);
      chk(route_valid_o == 1'b1, "R2 valid", int'(route_valid_o), 1);
      chk(out_port_o == VECS[i].port, "R4/R5/R6 table port", int'(out_port_o), int'(VECS[i].port));
      chk(vc_o == VECS[i].vc, "R8 table vc", int'(vc_o), int'(VECS[i].vc));
    end

    // exhaustive single-step compare
    for (int sx = 0; sx < K; sx++)
      for (int sy = 0; sy < K; sy++)
        for (int tx = 0; tx < K; tx++)
          for (int ty = 0; ty < K; ty++) begin
            exp_r = route_model(sx, sy, tx, ty);
            send_head(sx, sy, tx, ty);
            chk(out_port_o == exp_r[3:1], "R6 sweep port", int'(out_port_o), int'(exp_r[3:1]));
            chk(vc_o == exp_r[0], "R8 sweep vc", int'(vc_o), int'(exp_r[0]));
            if (sx == tx && sy == ty)
              chk(out_port_o == 3'd0 && vc_o == 1'b0, "R7 eject", int'(out_port_o), 0);
          end

    // R9 hop walks
    for (int sx = 0; sx < K; sx++)
      for (int sy = 0; sy < K; sy++)
        for (int tx = 0; tx < K; tx++)
          for (int ty = 0; ty < K; ty++) begin
            int cx, cy, hops;
            bit in_y, turn_bad;
            cx = sx; cy = sy; hops = 0; in_y = 1'b0; turn_bad = 1'b0;
            for (int s = 0; s < 2 * K; s++) begin
              send_head(cx, cy, tx, ty);
              if (out_port_o == 3'd0) break;
              case (out_port_o)
                3'd1: begin cx = (cx + 1) % K;     if (in_y) turn_bad = 1'b1; end
                3'd2: begin cx = (cx + K - 1) % K; if (in_y) turn_bad = 1'b1; end
                3'd3: begin cy = (cy + 1) % K;     in_y = 1'b1; end
                default: begin cy = (cy + K - 1) % K; in_y = 1'b1; end
              endcase
              hops++;
            end
            chk(cx == tx && cy == ty, "R9 arrival", cx * K + cy, tx * K + ty);
            chk(hops <= 2 * (K / 2), "R9 length", hops, 2 * (K / 2));
            chk(!turn_bad, "R9 no Y-to-X turn", int'(turn_bad), 0);
          end

    // R3 body flit with new coordinates holds route
    send_head(0, 0, 3, 0);
    hold_port = out_port_o; hold_vc = vc_o;
    @(negedge clk);
    cur_x_i = 2'd1; cur_y_i = 2'd1; dst_x_i = 2'd1; dst_y_i = 2'd2;
    flit_valid_i = 1'b1; flit_head_i = 1'b0;
    @(negedge clk);
    flit_valid_i = 1'b0;
    chk(route_valid_o == 1'b0, "R3 body no valid", int'(route_valid_o), 0);
    chk(out_port_o == hold_port, "R3 body port hold", int'(out_port_o), int'(hold_port));
    chk(vc_o == hold_vc, "R3 body vc hold", int'(vc_o), int'(hold_vc));
    // head flag without valid
    flit_head_i = 1'b1;
    @(negedge clk);
    flit_head_i = 1'b0;
    chk(route_valid_o == 1'b0, "R2 head without valid", int'(route_valid_o), 0);
    chk(out_port_o == hold_port, "R3 idle port hold", int'(out_port_o), int'(hold_port));

    // R1 reset mid-run
    send_head(0, 0, 3, 0);
    #3ns rst_ni = 1'b0;
    #2ns;
    chk(route_valid_o == 1'b0, "R1 midrun valid", int'(route_valid_o), 0);
    chk(out_port_o == 3'd0, "R1 midrun port", int'(out_port_o), 0);
    chk(vc_o == 1'b0, "R1 midrun vc", int'(vc_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule